// File: doc/BRIEF.md
# Eight-Direction Pixel Address Stepper

This block keeps track of the pixel that a figure-drawing engine is currently working on. The position is held as two pieces: the linear address of the 16-pixel display word that contains the pixel, and a one-hot 16-bit mask that marks the pixel inside that word. Display memory is a flat array of such words, with the pixels of a word lying side by side on one scan line. Mask bit 0 is the leftmost pixel of its word.

A step strobe moves the position to one of the eight neighbouring pixels. A 3-bit direction register selects the neighbour. Vertical motion adds or subtracts a programmable pitch, which is the number of words per line. Horizontal motion rotates the mask by one place. When the marked pixel crosses a word edge, the word address is carried up or borrowed down by one. A diagonal step applies both effects in the same clock.

The start word address, the dot position, the pitch and the direction each have their own load strobe. The drawing sequencer that picks the direction for each pixel sits outside this block. It issues at most one step per clock. The new address is ready on the outputs in the next clock, well inside one memory access.

Top module: `pix_step_top`

## Requirements
- R1: After reset the word address is 0, the mask is 16'h0001 (dot 0), the pitch is 0 and the direction is 0.
- R2: A load of the address takes `addr_in` on the next edge. A load of the dot sets the mask to `1 << dot_in`. Pitch and direction loads take effect for steps issued in later cycles.
- R3: Direction 0 (down) adds the pitch to the word address, and direction 4 (up) subtracts it. The mask is unchanged by both.
- R4: Direction 2 (right) moves the mask one bit toward the MSB, and direction 6 (left) moves it one bit toward the LSB. The address does not change while the marked bit stays inside the word.
- R5: A right step from mask bit 15 gives mask bit 0 and the address plus 1. A left step from mask bit 0 gives mask bit 15 and the address minus 1.
- R6: The diagonals combine one vertical and one horizontal move in a single step: 1 is down-right, 3 is up-right, 5 is up-left and 7 is down-left. This includes any word carry or borrow.
- R7: All word address arithmetic wraps modulo 2^18.
- R8: In a cycle with no step and no address or dot load, the word address and the mask hold their values.
- R9: A step in the same cycle as an address or dot load is discarded, and the loaded values win. A step in the same cycle as a pitch or direction load uses the pitch and direction held before that load.
- R10: The mask always has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_addr | input | 1 | Load the word address from `addr_in` |
| addr_in | input | 18 | Start word address |
| ld_dot | input | 1 | Load the dot position from `dot_in` |
| dot_in | input | 4 | Pixel index within the word, 0 = leftmost |
| ld_pitch | input | 1 | Load the pitch from `pitch_in` |
| pitch_in | input | 8 | Words per display line |
| ld_dir | input | 1 | Load the direction from `dir_in` |
| dir_in | input | 3 | Direction code 0..7 (0 down, counter-clockwise) |
| step | input | 1 | Move one pixel in the held direction |
| word_addr | output | 18 | Current word address |
| dot_mask | output | 16 | One-hot mask of the current pixel |

## Verification
Runs of straight vertical steps check the pitch arithmetic with the mask left alone. Runs of pure horizontal steps that cross both word edges tell the in-word rotation apart from the carry and borrow paths. Diagonal walks that start at mask bits 0 and 15 show whether the row offset and the column carry are added together in one step. Directed address-wrap cases and same-cycle load-and-step cases check the modulo arithmetic and the priority rules. A long seeded random mix of steps and loads is compared against a bench model that tracks the dot as an integer position.

// File: rtl/pix_step_pkg.sv
// Package: shared types and direction decoding for the pixel stepper.
// Assumes the direction code 0 = down, then counter-clockwise in 45 degree steps.
package pix_step_pkg;

    typedef enum logic [1:0] {
        H_STAY  = 2'd0,
        H_RIGHT = 2'd1,
        H_LEFT  = 2'd2
    } hmove_e;

    typedef enum logic [1:0] {
        V_STAY = 2'd0,
        V_DOWN = 2'd1,
        V_UP   = 2'd2
    } vmove_e;

    // Horizontal part of a direction code.
    function automatic hmove_e dir_h(input logic [2:0] d);
        case (d)
            3'd1, 3'd2, 3'd3: dir_h = H_RIGHT;
            3'd5, 3'd6, 3'd7: dir_h = H_LEFT;
            default:          dir_h = H_STAY;
        endcase
    endfunction

    // Vertical part of a direction code.
    function automatic vmove_e dir_v(input logic [2:0] d);
        case (d)
            3'd0, 3'd1, 3'd7: dir_v = V_DOWN;
            3'd3, 3'd4, 3'd5: dir_v = V_UP;
            default:          dir_v = V_STAY;
        endcase
    endfunction

endpackage

// File: rtl/pix_col_step.sv
// Column stepper: rotates the one-hot dot mask by one place and flags a
// carry (wrap past the MSB) or a borrow (wrap past the LSB).
// Assumes mask_q is one-hot; bit 0 is the leftmost pixel of a word.
module pix_col_step
    import pix_step_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] mask_q,
    input  hmove_e            hmove,
    output logic [WORD_W-1:0] mask_nx,
    output logic              carry_up,
    output logic              carry_dn
);

    logic [WORD_W-1:0] rot_msb;   // mask moved toward the MSB (rightward)
    logic [WORD_W-1:0] rot_lsb;   // mask moved toward the LSB (leftward)

    // Both rotations built bit by bit; the end bits feed across the word.
    for (genvar i = 0; i < WORD_W; i++) begin : g_rot
        assign rot_msb[i] = mask_q[(i + WORD_W - 1) % WORD_W];
        assign rot_lsb[i] = mask_q[(i + 1) % WORD_W];
    end

    // Select the rotation and raise the word carry or borrow on an edge crossing.
    always_comb begin
        mask_nx  = mask_q;
        carry_up = 1'b0;
        carry_dn = 1'b0;
        case (hmove)
            H_RIGHT: begin
                mask_nx  = rot_msb;
                carry_up = mask_q[WORD_W-1];
            end
            H_LEFT: begin
                mask_nx  = rot_lsb;
                carry_dn = mask_q[0];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pix_row_step.sv
// Row stepper: turns the vertical part of a move into a signed word offset
// of plus or minus the pitch, in ADDR_W-bit two's complement.
// Assumes PITCH_W <= ADDR_W.
module pix_row_step
    import pix_step_pkg::*;
#(
    parameter int ADDR_W  = 18,
    parameter int PITCH_W = 8
) (
    input  logic [PITCH_W-1:0] pitch_q,
    input  vmove_e             vmove,
    output logic [ADDR_W-1:0]  row_delta
);

    logic [ADDR_W-1:0] pitch_ext;

    assign pitch_ext = ADDR_W'(pitch_q);

    // Pick +pitch, -pitch or zero for the row offset.
    always_comb begin
        case (vmove)
            V_DOWN:  row_delta = pitch_ext;
            V_UP:    row_delta = ADDR_W'(0) - pitch_ext;
            default: row_delta = '0;
        endcase
    end

endmodule

// File: rtl/pix_addr_sum.sv
// Address adder: adds the row offset and the column carry or borrow to the
// current word address, wrapping modulo 2^ADDR_W.
// Assumes carry_up and carry_dn are never both set.
module pix_addr_sum #(
    parameter int ADDR_W = 18
) (
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [ADDR_W-1:0] row_delta,
    input  logic              carry_up,
    input  logic              carry_dn,
    output logic [ADDR_W-1:0] addr_nx
);

    logic [ADDR_W-1:0] col_adj;

    // Column adjustment: +1, -1 (all ones) or zero.
    always_comb begin
        if (carry_up)      col_adj = ADDR_W'(1);
        else if (carry_dn) col_adj = '1;
        else               col_adj = '0;
    end

    // Three-input sum; the natural width truncation gives the modulo wrap.
    assign addr_nx = addr_q + row_delta + col_adj;

endmodule

// File: rtl/pix_step_top.sv
// Pixel position stepper: holds the word address, dot mask, pitch and
// direction, and on each step moves the position to one of the eight
// neighbouring pixels. An address or dot load in the same cycle as a step
// wins over the step. Pitch and direction loads apply to later steps.
// Assumes WORD_W is a power of two, DOT_W = log2(WORD_W), and at most one step per clock.
module pix_step_top
    import pix_step_pkg::*;
#(
    parameter int ADDR_W  = 18,
    parameter int PITCH_W = 8,
    parameter int WORD_W  = 16,
    parameter int DOT_W   = $clog2(WORD_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_addr,
    input  logic [ADDR_W-1:0]  addr_in,
    input  logic               ld_dot,
    input  logic [DOT_W-1:0]   dot_in,
    input  logic               ld_pitch,
    input  logic [PITCH_W-1:0] pitch_in,
    input  logic               ld_dir,
    input  logic [2:0]         dir_in,
    input  logic               step,
    output logic [ADDR_W-1:0]  word_addr,
    output logic [WORD_W-1:0]  dot_mask
);

    logic [ADDR_W-1:0]  addr_q;
    logic [WORD_W-1:0]  mask_q;
    logic [PITCH_W-1:0] pitch_q;
    logic [2:0]         dir_q;

    logic               step_go;
    hmove_e             hmove;
    vmove_e             vmove;
    logic [WORD_W-1:0]  mask_nx;
    logic               carry_up;
    logic               carry_dn;
    logic [ADDR_W-1:0]  row_delta;
    logic [ADDR_W-1:0]  addr_nx;
    logic [WORD_W-1:0]  dot_onehot;

    // A step counts only when neither position register is being loaded.
    assign step_go = step & ~ld_addr & ~ld_dot;

    // Split the held direction into its row and column parts.
    always_comb begin
        hmove = step_go ? dir_h(dir_q) : H_STAY;
        vmove = step_go ? dir_v(dir_q) : V_STAY;
    end

    // Decode the loaded dot index to a one-hot mask.
    for (genvar k = 0; k < WORD_W; k++) begin : g_dot
        assign dot_onehot[k] = (dot_in == DOT_W'(k));
    end

    pix_col_step #(
        .WORD_W (WORD_W)
    ) u_col (
        .mask_q   (mask_q),
        .hmove    (hmove),
        .mask_nx  (mask_nx),
        .carry_up (carry_up),
        .carry_dn (carry_dn)
    );

    pix_row_step #(
        .ADDR_W  (ADDR_W),
        .PITCH_W (PITCH_W)
    ) u_row (
        .pitch_q   (pitch_q),
        .vmove     (vmove),
        .row_delta (row_delta)
    );

    pix_addr_sum #(
        .ADDR_W (ADDR_W)
    ) u_sum (
        .addr_q    (addr_q),
        .row_delta (row_delta),
        .carry_up  (carry_up),
        .carry_dn  (carry_dn),
        .addr_nx   (addr_nx)
    );

    // Position registers: a load wins, otherwise take the stepped value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            mask_q <= WORD_W'(1);
        end else begin
            addr_q <= ld_addr ? addr_in : addr_nx;
            mask_q <= ld_dot ? dot_onehot : mask_nx;
        end
    end

    // Setup registers: pitch and direction, loaded by the host side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pitch_q <= '0;
            dir_q   <= 3'd0;
        end else begin
            if (ld_pitch) pitch_q <= pitch_in;
            if (ld_dir)   dir_q   <= dir_in;
        end
    end

    assign word_addr = addr_q;
    assign dot_mask  = mask_q;

endmodule

// File: rtl/pix_step_chk.sv
// Checker for pix_step_top: temporal properties over ports and the held
// direction. Attached to every instance of the top through bind.
module pix_step_chk #(
    parameter int ADDR_W = 18,
    parameter int WORD_W = 16,
    parameter int DOT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_addr,
    input logic [ADDR_W-1:0] addr_in,
    input logic              ld_dot,
    input logic [DOT_W-1:0]  dot_in,
    input logic              step,
    input logic [2:0]        dir_q,
    input logic [ADDR_W-1:0] word_addr,
    input logic [WORD_W-1:0] dot_mask
);

    logic quiet;
    assign quiet = !ld_addr && !ld_dot;

    AST_MASK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(dot_mask) == 1); // R10

    AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ld_addr |=> word_addr == $past(addr_in)); // R2

    AST_DOT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ld_dot |=> dot_mask == (WORD_W'(1) << $past(dot_in))); // R2

    AST_VERT_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (step && quiet && (dir_q == 3'd0 || dir_q == 3'd4)) |=> $stable(dot_mask)); // R3

    AST_RIGHT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && quiet && dir_q == 3'd2 && dot_mask[WORD_W-1])
        |=> (dot_mask == WORD_W'(1) && word_addr == $past(word_addr) + ADDR_W'(1))); // R5

    AST_LEFT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && quiet && dir_q == 3'd6 && dot_mask[0])
        |=> (dot_mask[WORD_W-1] && word_addr == $past(word_addr) - ADDR_W'(1))); // R5

    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && quiet) |=> ($stable(word_addr) && $stable(dot_mask))); // R8

endmodule

bind pix_step_top pix_step_chk #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W),
    .DOT_W  (DOT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_addr   (ld_addr),
    .addr_in   (addr_in),
    .ld_dot    (ld_dot),
    .dot_in    (dot_in),
    .step      (step),
    .dir_q     (dir_q),
    .word_addr (word_addr),
    .dot_mask  (dot_mask)
);

// File: tb/sim_pix_step_top.sv
`timescale 1ns/1ps
module sim_pix_step_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_addr = 1'b0;
    logic [17:0] addr_in = '0;
    logic        ld_dot = 1'b0;
    logic [3:0]  dot_in = '0;
    logic        ld_pitch = 1'b0;
    logic [7:0]  pitch_in = '0;
    logic        ld_dir = 1'b0;
    logic [2:0]  dir_in = '0;
    logic        step = 1'b0;
    logic [17:0] word_addr;
    logic [15:0] dot_mask;

    int nchk = 0;
    int nfail = 0;

    // Bench model: dot kept as an integer column, not as a mask.
    logic [17:0] m_addr = '0;
    int          m_col = 0;
    logic [7:0]  m_pitch = '0;
    logic [2:0]  m_dir = '0;

    always #2.5 clk = ~clk;

    pix_step_top u0 (
        .clk(clk), .rst_n(rst_n),
        .ld_addr(ld_addr), .addr_in(addr_in),
        .ld_dot(ld_dot), .dot_in(dot_in),
        .ld_pitch(ld_pitch), .pitch_in(pitch_in),
        .ld_dir(ld_dir), .dir_in(dir_in),
        .step(step), .word_addr(word_addr), .dot_mask(dot_mask)
    );

    // Expected position after one step of the model.
    function automatic void model_step();
        if (m_dir == 3'd0 || m_dir == 3'd1 || m_dir == 3'd7) m_addr = m_addr + 18'(m_pitch);
        if (m_dir == 3'd3 || m_dir == 3'd4 || m_dir == 3'd5) m_addr = m_addr - 18'(m_pitch);
        if (m_dir == 3'd1 || m_dir == 3'd2 || m_dir == 3'd3) begin
            if (m_col == 15) begin m_col = 0; m_addr = m_addr + 18'd1; end
            else m_col = m_col + 1;
        end
        if (m_dir == 3'd5 || m_dir == 3'd6 || m_dir == 3'd7) begin
            if (m_col == 0) begin m_col = 15; m_addr = m_addr - 18'd1; end
            else m_col = m_col - 1;
        end
    endfunction

    task automatic chk(input string tag);
        logic [15:0] em;
        em = 16'd0;
        em[m_col] = 1'b1;
        nchk++;
        if (word_addr !== m_addr || dot_mask !== em) begin
            nfail++;
            $display("FAIL %s: addr=%h mask=%h expected addr=%h mask=%h",
                     tag, word_addr, dot_mask, m_addr, em);
        end
    endtask

    // One clock: drive at the falling edge, update the model at the rising edge, check after it.
    task automatic cyc(input logic la, input logic [17:0] a, input logic ld, input logic [3:0] d,
                       input logic lp, input logic [7:0] p, input logic lr, input logic [2:0] r,
                       input logic st, input string tag);
        @(negedge clk);
        ld_addr = la; addr_in = a; ld_dot = ld; dot_in = d;
        ld_pitch = lp; pitch_in = p; ld_dir = lr; dir_in = r; step = st;
        @(posedge clk);
        if (st && !la && !ld) model_step();
        if (la) m_addr = a;
        if (ld) m_col = int'(d);
        if (lp) m_pitch = p;
        if (lr) m_dir = r;
        #1;
        chk(tag);
    endtask

    task automatic setup(input logic [17:0] a, input logic [3:0] d, input logic [7:0] p,
                         input logic [2:0] r, input string tag);
        cyc(1, a, 1, d, 1, p, 1, r, 0, tag);
    endtask

    task automatic steps(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(0, '0, 0, '0, 0, '0, 0, '0, 1, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset state");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 after reset release");

        // Loads
        setup(18'h01234, 4'd7, 8'd40, 3'd0, "R2 load all");
        cyc(0, '0, 1, 4'd15, 0, '0, 0, '0, 0, "R2 dot load 15");
        // Vertical
        steps(3, "R3 down");
        cyc(0, '0, 0, '0, 0, '0, 1, 3'd4, 0, "R2 dir load");
        steps(5, "R3 up");
        // Horizontal within word and wraps
        setup(18'h00100, 4'd3, 8'd20, 3'd2, "R4 setup right");
        steps(12, "R4 right in word");
        steps(3, "R5 right wrap");
        setup(18'h00100, 4'd2, 8'd20, 3'd6, "R4 setup left");
        steps(2, "R4 left in word");
        steps(3, "R5 left wrap");
        // Diagonals from both edges
        for (int dd = 1; dd < 8; dd += 2) begin
            setup(18'h02000, 4'd15, 8'd33, 3'(dd), "R6 setup diag hi");
            steps(2, "R6 diagonal from bit 15");
            setup(18'h02000, 4'd0, 8'd33, 3'(dd), "R6 setup diag lo");
            steps(2, "R6 diagonal from bit 0");
        end
        // Address wrap
        setup(18'h00005, 4'd0, 8'd200, 3'd4, "R7 setup up wrap");
        steps(1, "R7 up past zero");
        setup(18'h3FFFF, 4'd15, 8'd0, 3'd2, "R7 setup right wrap");
        steps(1, "R7 carry past top");
        setup(18'h3FF80, 4'd8, 8'd255, 3'd0, "R7 setup down wrap");
        steps(1, "R7 down past top");
        // Hold
        for (int i = 0; i < 4; i++) cyc(0, 18'h155, 0, 4'd9, 0, '0, 0, '0, 0, "R8 hold");
        // Same-cycle priority
        setup(18'h00400, 4'd5, 8'd10, 3'd1, "R9 setup");
        cyc(1, 18'h00777, 0, '0, 0, '0, 0, '0, 1, "R9 addr load beats step");
        cyc(0, '0, 1, 4'd12, 0, '0, 0, '0, 1, "R9 dot load beats step");
        cyc(0, '0, 0, '0, 1, 8'd99, 1, 3'd5, 1, "R9 step uses old pitch and dir");
        steps(1, "R9 new pitch and dir apply");

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            int unsigned rr;
            rr = $urandom % 100;
            cyc(rr < 4, 18'($urandom), (rr >= 4 && rr < 8), 4'($urandom),
                ($urandom % 20) == 0, 8'($urandom), ($urandom % 6) == 0, 3'($urandom),
                ($urandom % 10) < 8, "R10 random mix");
        end

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule